// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address. It shifts a 16-bit segment base left by four bit positions and adds the offset to it. Four segment base registers live inside the block: code, data, stack and extra. Each has a write port. The kind of access picks which base is used: an instruction fetch, a stack-relative access, a general data access, or the destination of a string move. An override input can replace that default choice for stack and data accesses.

The block also holds the source and destination string index registers. On request it steps either one by one (byte) or by two (word). It counts up when the direction input is low and down when it is high. For a string-destination access the block takes the destination index as the offset, so the caller does not present it. The physical address and the identity of the segment used are registered, and both appear one clock after the access is presented.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted, and at the first sample after it, all four segment bases, both index registers, `phys_addr` and `seg_used` read zero.
- R2: One clock after an access is presented, `phys_addr` equals (selected base × 16 + offset). A segment base written in one cycle is the value used by an access presented in the next cycle.
- R3: A fetch access (`acc_kind` = 0) always uses the code base (`seg_used` = 0), whatever the override inputs are.
- R4: A stack access (`acc_kind` = 1) with no override uses the stack base (`seg_used` = 2).
- R5: A data access (`acc_kind` = 2) with no override uses the data base (`seg_used` = 1).
- R6: For stack and data accesses, `ovr_en` = 1 selects the base named by `ovr_sel` (0 code, 1 data, 2 stack, 3 extra), and `seg_used` reports that choice.
- R7: A string-destination access (`acc_kind` = 3) uses the extra base (`seg_used` = 3) and the destination index as its offset. It ignores both the override inputs and the `offset` input.
- R8: A step request changes the selected index by 1 when `str_word` = 0 and by 2 when `str_word` = 1. The index goes up when `dir_flag` = 0 and down when it is 1. The result wraps within 16 bits, and the new value is visible one clock later.
- R9: A load of an index register takes priority over a step request for the same register in the same cycle. The other index register is left unchanged.
- R10: When base × 16 + offset exceeds 0xFFFFF, `phys_addr` wraps modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Write a segment base |
| seg_wr_sel | input | 2 | Base to write: 0 code, 1 data, 2 stack, 3 extra |
| seg_wr_data | input | 16 | New base value |
| acc_kind | input | 2 | 0 fetch, 1 stack, 2 data, 3 string destination |
| ovr_en | input | 1 | Use `ovr_sel` instead of the default base |
| ovr_sel | input | 2 | Override base, same encoding as `seg_wr_sel` |
| offset | input | 16 | Offset for access kinds 0 to 2 |
| idx_ld_src | input | 1 | Load the source index |
| idx_ld_dst | input | 1 | Load the destination index |
| idx_ld_data | input | 16 | Value to load |
| step_src | input | 1 | Step the source index |
| step_dst | input | 1 | Step the destination index |
| str_word | input | 1 | Step size: 0 byte (1), 1 word (2) |
| dir_flag | input | 1 | 0 count up, 1 count down |
| phys_addr | output | 20 | Registered physical address |
| seg_used | output | 2 | Registered identity of the base used |
| src_idx | output | 16 | Source index register |
| dst_idx | output | 16 | Destination index register |

## Verification
The corners that are hardest to reach from the ports are the two wrap cases. Reaching a 20-bit address wrap takes a base near 0xFFFF plus a non-trivial offset. Reaching a 16-bit index wrap takes a load to 0xFFFF or 0x0000 followed by a step in the direction that crosses the boundary. The stimulus first writes the stack base to 0xFFFF and then presents offsets that land both at and past the top of memory. It also loads indices to their edge values before stepping them both ways. The string-destination path is reached by loading the destination index and then requesting an access with a conflicting override and a misleading offset, so that any leak of either shows up in the address.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int NUM_SEG = 4;
    localparam int SEL_W   = $clog2(NUM_SEG);

    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_STACK  = 2'd1,
        ACC_DATA   = 2'd2,
        ACC_STRDST = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [SEG_W-1:0]               wr_data,
    input  logic [SEL_W-1:0]               rd_sel,
    output logic [SEG_W-1:0]               rd_data
);
    logic [NUM_SEG-1:0][SEG_W-1:0] seg_d, seg_q;

    always_comb begin
        seg_d = seg_q;
        if (wr_en) seg_d[wr_sel] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seg_q <= '0;
        else        seg_q <= seg_d;
    end

    assign rd_data = seg_q[rd_sel];

    // R2: a written base holds the written value on the following cycle
    assert_base_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> seg_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_pkg::*;
(
    input  logic [1:0]       acc_kind,
    input  logic             ovr_en,
    input  logic [SEL_W-1:0] ovr_sel,
    output logic [SEL_W-1:0] sel
);
    acc_kind_e kind;
    seg_id_e   chosen;

    always_comb begin
        kind = acc_kind_e'(acc_kind);
        unique case (kind)
            ACC_FETCH:  chosen = SEG_CODE;
            ACC_STACK:  chosen = ovr_en ? seg_id_e'(ovr_sel) : SEG_STACK;
            ACC_DATA:   chosen = ovr_en ? seg_id_e'(ovr_sel) : SEG_DATA;
            default:    chosen = SEG_EXTRA;
        endcase
        sel = chosen;
    end

    always_comb begin
        if (kind == ACC_FETCH)  assert_fetch_code_R3: assert (sel == SEG_CODE);
        if (kind == ACC_STRDST) assert_strdst_extra_R7: assert (sel == SEG_EXTRA);
    end
endmodule

// File: rtl/idx_stepper.sv
module idx_stepper #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step_en,
    input  logic             word,
    input  logic             dir_dn,
    output logic [IDX_W-1:0] val
);
    logic [IDX_W-1:0] val_d, val_q, stride;

    always_comb begin
        stride = word ? IDX_W'(2) : IDX_W'(1);
        val_d  = val_q;
        if (load_en)      val_d = load_val;
        else if (step_en) val_d = dir_dn ? (val_q - stride) : (val_q + stride);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val = val_q;

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> val_q == $past(load_val));
    assert_step_up_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && !dir_dn && !word) |=> val_q == IDX_W'($past(val_q) + 1'b1));
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> $stable(val_q));
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        seg_wr_en,
    input  logic [1:0]                  seg_wr_sel,
    input  logic [OFS_W-1:0]            seg_wr_data,
    input  logic [1:0]                  acc_kind,
    input  logic                        ovr_en,
    input  logic [1:0]                  ovr_sel,
    input  logic [OFS_W-1:0]            offset,
    input  logic                        idx_ld_src,
    input  logic                        idx_ld_dst,
    input  logic [OFS_W-1:0]            idx_ld_data,
    input  logic                        step_src,
    input  logic                        step_dst,
    input  logic                        str_word,
    input  logic                        dir_flag,
    output logic [OFS_W+SEG_SHIFT-1:0]  phys_addr,
    output logic [1:0]                  seg_used,
    output logic [OFS_W-1:0]            src_idx,
    output logic [OFS_W-1:0]            dst_idx
);
    localparam int PA_W = OFS_W + SEG_SHIFT;

    typedef struct packed {
        logic [PA_W-1:0]  pa;
        logic [SEL_W-1:0] seg;
    } out_t;

    out_t             out_d, out_q;
    logic [SEL_W-1:0] sel;
    logic [OFS_W-1:0] base, eff_ofs;
    logic [OFS_W-1:0] idx_val [2];
    logic             ld_vec  [2];
    logic             st_vec  [2];

    seg_regfile #(.SEG_W(OFS_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(seg_wr_en), .wr_sel(seg_wr_sel), .wr_data(seg_wr_data),
        .rd_sel(sel), .rd_data(base)
    );

    seg_select u_sel (
        .acc_kind(acc_kind), .ovr_en(ovr_en), .ovr_sel(ovr_sel), .sel(sel)
    );

    assign ld_vec[0] = idx_ld_src;
    assign ld_vec[1] = idx_ld_dst;
    assign st_vec[0] = step_src;
    assign st_vec[1] = step_dst;

    for (genvar g = 0; g < 2; g++) begin : g_idx
        idx_stepper #(.IDX_W(OFS_W)) u_step (
            .clk(clk), .rst_n(rst_n),
            .load_en(ld_vec[g]), .load_val(idx_ld_data),
            .step_en(st_vec[g]), .word(str_word), .dir_dn(dir_flag),
            .val(idx_val[g])
        );
    end

    always_comb begin
        eff_ofs   = (acc_kind_e'(acc_kind) == ACC_STRDST) ? idx_val[1] : offset;
        out_d.pa  = ({{SEG_SHIFT{1'b0}}, base} << SEG_SHIFT) + {{SEG_SHIFT{1'b0}}, eff_ofs};
        out_d.seg = sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign phys_addr = out_q.pa;
    assign seg_used  = out_q.seg;
    assign src_idx   = idx_val[0];
    assign dst_idx   = idx_val[1];

    assert_fetch_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_kind == 2'd0 |=> seg_used == 2'd0);
    assert_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en && (acc_kind == 2'd1 || acc_kind == 2'd2)) |=> seg_used == $past(ovr_sel));
    assert_strdst_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_kind == 2'd3 |=> seg_used == 2'd3);
endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        seg_wr_en = 0;
    logic [1:0]  seg_wr_sel = 0;
    logic [15:0] seg_wr_data = 0;
    logic [1:0]  acc_kind = 0;
    logic        ovr_en = 0;
    logic [1:0]  ovr_sel = 0;
    logic [15:0] offset = 0;
    logic        idx_ld_src = 0, idx_ld_dst = 0;
    logic [15:0] idx_ld_data = 0;
    logic        step_src = 0, step_dst = 0, str_word = 0, dir_flag = 0;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;
    logic [15:0] src_idx, dst_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    seg_addr_gen u0 (.*);

    // {kind, ovr_en, ovr_sel, offset, expected address, expected base id}
    localparam logic [42:0] VEC [7] = '{
        {2'd0, 1'b0, 2'd0, 16'h0010, 20'h12350, 2'd0},   // R3 fetch
        {2'd0, 1'b1, 2'd1, 16'h0005, 20'h12345, 2'd0},   // R3 override ignored
        {2'd1, 1'b0, 2'd0, 16'h0010, 20'h00000, 2'd2},   // R10 wrap to zero
        {2'd1, 1'b0, 2'd0, 16'h0002, 20'hFFFF2, 2'd2},   // R4 stack
        {2'd2, 1'b0, 2'd0, 16'hABCD, 20'h2ABCD, 2'd1},   // R5 data
        {2'd2, 1'b1, 2'd3, 16'h0001, 20'h01001, 2'd3},   // R6 data->extra
        {2'd1, 1'b1, 2'd0, 16'h0000, 20'h12340, 2'd0}    // R6 stack->code
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_seg(logic [1:0] s, logic [15:0] v);
        @(negedge clk);
        seg_wr_en = 1; seg_wr_sel = s; seg_wr_data = v;
        @(negedge clk);
        seg_wr_en = 0;
    endtask

    task automatic quiet();
        idx_ld_src = 0; idx_ld_dst = 0; step_src = 0; step_dst = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 phys_addr", 32'(phys_addr), 0);
        check("R1 seg_used", 32'(seg_used), 0);
        check("R1 src_idx", 32'(src_idx), 0);
        check("R1 dst_idx", 32'(dst_idx), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", 32'(phys_addr), 0);

        wr_seg(2'd0, 16'h1234);
        wr_seg(2'd1, 16'h2000);
        wr_seg(2'd2, 16'hFFFF);
        wr_seg(2'd3, 16'h0100);

        for (int i = 0; i < 7; i++) begin
            {acc_kind, ovr_en, ovr_sel, offset} = VEC[i][42:22];
            @(negedge clk);
            check($sformatf("R2 vec%0d addr", i), 32'(phys_addr), 32'(VEC[i][21:2]));
            check($sformatf("R2 vec%0d base id", i), 32'(seg_used), 32'(VEC[i][1:0]));
        end
        ovr_en = 0;

        // R2: write then immediate use
        seg_wr_en = 1; seg_wr_sel = 2'd1; seg_wr_data = 16'h3000;
        @(negedge clk);
        seg_wr_en = 0; acc_kind = 2'd2; offset = 16'h0000;
        @(negedge clk);
        check("R2 new base next cycle", 32'(phys_addr), 32'h30000);

        // R10 partial wrap
        acc_kind = 2'd1; offset = 16'h0123;
        @(negedge clk);
        check("R10 wrap", 32'(phys_addr), 32'h00113);

        // R7 string destination
        idx_ld_dst = 1; idx_ld_data = 16'h0010;
        @(negedge clk);
        quiet();
        acc_kind = 2'd3; ovr_en = 1; ovr_sel = 2'd0; offset = 16'h7777;
        @(negedge clk);
        check("R7 addr", 32'(phys_addr), 32'h01010);
        check("R7 base id", 32'(seg_used), 3);
        ovr_en = 0; acc_kind = 2'd0;

        // R8 stepping with wrap
        idx_ld_src = 1; idx_ld_data = 16'hFFFF;
        @(negedge clk);
        quiet(); step_src = 1; str_word = 0; dir_flag = 0;
        @(negedge clk);
        quiet();
        check("R8 byte up wrap", 32'(src_idx), 0);
        step_src = 1; str_word = 1; dir_flag = 1;
        @(negedge clk);
        quiet();
        check("R8 word down wrap", 32'(src_idx), 32'hFFFE);
        step_dst = 1; str_word = 1; dir_flag = 0;
        @(negedge clk);
        quiet();
        check("R8 dst word up", 32'(dst_idx), 32'h0012);
        check("R9 src untouched", 32'(src_idx), 32'hFFFE);
        step_dst = 1; str_word = 0; dir_flag = 1;
        @(negedge clk);
        quiet();
        check("R8 dst byte down", 32'(dst_idx), 32'h0011);

        // R9 load beats step
        idx_ld_src = 1; step_src = 1; idx_ld_data = 16'h4000; dir_flag = 0;
        @(negedge clk);
        quiet();
        check("R9 load priority", 32'(src_idx), 32'h4000);
        check("R9 dst unchanged", 32'(dst_idx), 32'h0011);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule